// File: doc/BRIEF.md
# Two-Way Handshake Sequencer / Fork-Join Controller

This block takes one four-phase activation handshake and drives two outgoing four-phase handshakes from it. In ordered mode it runs branch 0 through a whole request/acknowledge cycle and only then starts branch 1. The activation acknowledge comes straight from branch 1's acknowledge. In parallel mode it raises both branch requests together. It drops each branch request as soon as that branch acknowledges. It joins completion with a registered Muller C-element, so the activation acknowledge is high only after both branches have acknowledged. It falls only after every handshake wire has returned to zero.

The design is clocked and samples the handshake wires on every rising edge. An optional input synchronizer depth can be set by a parameter. The mode input is captured into an internal register, and that register is loaded only while all handshake wires are low. A controller can therefore be built into a larger control network and switched between ordered and parallel operation between activations.

Top module: `hsc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, act_ack and both bits of br_req are 0.
- R2: One clock edge after act_req is sampled high in an idle controller, br_req[0] is 1. In ordered mode br_req[1] stays 0 at that point.
- R3: Ordered mode: br_req[0] falls on the edge after br_ack[0] is sampled high. br_req[1] rises on the edge after br_ack[0] is sampled low again. The two requests are never high together.
- R4: Ordered mode: act_ack equals br_ack[1] in the same cycle, with no register between them.
- R5: Ordered mode: br_req[1] falls on the edge after act_req is sampled low. act_ack then falls together with br_ack[1].
- R6: Parallel mode: both br_req bits rise on the same edge, one edge after act_req is sampled high.
- R7: Parallel mode: each br_req[i] falls on the edge after its own br_ack[i] is sampled high, whatever the other branch is doing.
- R8: Parallel mode: act_ack rises on the edge after the later of the two branch acknowledges is sampled high. At that point both branch requests are already low.
- R9: Parallel mode: act_ack falls on the edge after act_req and both br_ack bits are all sampled low.
- R10: conc_mode (0 = ordered, 1 = parallel) takes effect only on an edge where the controller is idle and all handshake wires are low. A change during an activation has no effect on that activation.
- R11: Every branch channel obeys the four-phase rule: a request never rises while its acknowledge is high, and never falls while its acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| conc_mode | input | 1 | Mode select: 0 ordered, 1 parallel; captured only when idle |
| act_req | input | 1 | Activation request (passive side) |
| act_ack | output | 1 | Activation acknowledge |
| br_req | output | 2 | Branch requests, bit i drives branch i |
| br_ack | input | 2 | Branch acknowledges, bit i from branch i |

## Verification
With the default of no input synchronizer, every request output is due one rising edge after the input that causes it. Ordered-mode act_ack is due in the same cycle as br_ack[1]. Parallel-mode act_ack is due one edge after the join or release condition is met. The bench drives every input on the falling edge, then on each following falling edge it reads the outputs before it drives anything new. A result therefore first appears one sample after its cause. From each branch's acknowledge delay, the bench works out the exact sample index at which each request edge and each act_ack edge must appear, and compares against the recorded indices. It sweeps both modes over every pair of branch delays from 1 to 4, and also flips the mode in the middle of an activation.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

   localparam int unsigned NUM_BR = 2;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_B0_UP,
      SQ_B0_DN,
      SQ_B1_UP,
      SQ_B1_DN
   } sq_state_t;

endpackage

// File: rtl/hsc_muller_c.sv
module hsc_muller_c #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] in,
   output logic         out
);

   initial begin
      if (N < 2) $error("hsc_muller_c: N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out <= 1'b0;
      else if (&in)       out <= 1'b1;
      else if (!(|in))    out <= 1'b0;
   end

endmodule

// File: rtl/hsc_seq_engine.sv
module hsc_seq_engine
   import hsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              act_req,
   input  logic [NUM_BR-1:0] ack,
   output logic [NUM_BR-1:0] req,
   output logic              idle
);

   sq_state_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         req <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (en && act_req) begin
               req[0] <= 1'b1;
               st     <= SQ_B0_UP;
            end
            SQ_B0_UP: if (ack[0]) begin
               req[0] <= 1'b0;
               st     <= SQ_B0_DN;
            end
            SQ_B0_DN: if (!ack[0]) begin
               req[1] <= 1'b1;
               st     <= SQ_B1_UP;
            end
            SQ_B1_UP: if (!act_req) begin
               req[1] <= 1'b0;
               st     <= SQ_B1_DN;
            end
            SQ_B1_DN: if (!ack[1]) begin
               st <= SQ_IDLE;
            end
            default: begin
               req <= '0;
               st  <= SQ_IDLE;
            end
         endcase
      end
   end

   assign idle = (st == SQ_IDLE);

endmodule

// File: rtl/hsc_conc_engine.sv
module hsc_conc_engine
   import hsc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              act_req,
   input  logic [NUM_BR-1:0] ack,
   output logic [NUM_BR-1:0] req,
   output logic              done,
   output logic              idle
);

   logic              busy;
   logic              c_out;
   logic              start;
   logic [NUM_BR-1:0] seen;
   logic [NUM_BR-1:0] seen_nx;

   assign start = en & act_req & ~busy & ~c_out;

   // Per-branch completion flag: set by the branch acknowledge, cleared
   // only after the join fired, the activation request dropped and the
   // branch acknowledge returned low.
   always_comb begin
      for (int i = 0; i < int'(NUM_BR); i++) begin
         if (busy && ack[i])                       seen_nx[i] = 1'b1;
         else if (c_out && !act_req && !ack[i])    seen_nx[i] = 1'b0;
         else                                      seen_nx[i] = seen[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         seen <= '0;
         req  <= '0;
      end else begin
         seen <= seen_nx;
         if (start)                           busy <= 1'b1;
         else if (c_out && (seen_nx == '0))   busy <= 1'b0;
         for (int i = 0; i < int'(NUM_BR); i++) begin
            if (start)        req[i] <= 1'b1;
            else if (ack[i])  req[i] <= 1'b0;
         end
      end
   end

   hsc_muller_c #(.N(NUM_BR)) u_join (
      .clk   (clk),
      .rst_n (rst_n),
      .in    (seen_nx),
      .out   (c_out)
   );

   assign done = c_out;
   assign idle = ~busy & ~c_out;

endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
   import hsc_pkg::*;
#(
   parameter int unsigned IN_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conc_mode,
   input  logic              act_req,
   output logic              act_ack,
   output logic [NUM_BR-1:0] br_req,
   input  logic [NUM_BR-1:0] br_ack
);

   localparam int unsigned SW = NUM_BR + 1;

   initial begin
      if (IN_SYNC > 3) $error("hsc_ctrl: IN_SYNC must be 0..3");
   end

   logic [SW-1:0]     raw_in;
   logic [SW-1:0]     syn_in;
   logic              act_s;
   logic [NUM_BR-1:0] ack_s;

   assign raw_in = {act_req, br_ack};

   generate
      if (IN_SYNC == 0) begin : g_direct
         assign syn_in = raw_in;
      end else begin : g_sync
         logic [IN_SYNC-1:0][SW-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe <= '0;
            end else begin
               pipe[0] <= raw_in;
               for (int k = 1; k < int'(IN_SYNC); k++) pipe[k] <= pipe[k-1];
            end
         end
         assign syn_in = pipe[IN_SYNC-1];
      end
   endgenerate

   assign act_s = syn_in[SW-1];
   assign ack_s = syn_in[NUM_BR-1:0];

   logic              mode_q;
   logic [NUM_BR-1:0] seq_req;
   logic [NUM_BR-1:0] conc_req;
   logic              seq_idle;
   logic              conc_idle;
   logic              conc_done;

   hsc_seq_engine u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (~mode_q),
      .act_req (act_s),
      .ack     (ack_s),
      .req     (seq_req),
      .idle    (seq_idle)
   );

   hsc_conc_engine u_conc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (mode_q),
      .act_req (act_s),
      .ack     (ack_s),
      .req     (conc_req),
      .done    (conc_done),
      .idle    (conc_idle)
   );

   logic quiet;
   assign quiet = seq_idle & conc_idle & ~act_s & ~act_ack & (ack_s == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mode_q <= 1'b0;
      else if (quiet) mode_q <= conc_mode;
   end

   assign br_req  = mode_q ? conc_req  : seq_req;
   assign act_ack = mode_q ? conc_done : br_ack[NUM_BR-1];

endmodule

// File: rtl/hsc_ctrl_chk.sv
module hsc_ctrl_chk
   import hsc_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              mode_q,
   input logic              act_ack,
   input logic [NUM_BR-1:0] br_req,
   input logic [NUM_BR-1:0] ack_s
);

   generate
      for (genvar i = 0; i < int'(NUM_BR); i++) begin : g_ch
         // R11: request drops only after its acknowledge was seen high
         a_r11_req_fall_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(br_req[i]) |-> $past(ack_s[i]));
         // R11: request rises only while its acknowledge is low
         a_r11_req_rise_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(br_req[i]) |-> !$past(ack_s[i]));
      end
   endgenerate

   // R3: ordered mode never has both branches requesting
   a_r3_seq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> !(br_req[0] && br_req[1]));

   // R6: parallel mode forks both branches on one edge
   a_r6_conc_fork: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && $rose(br_req[0])) |-> br_req[1]);

   // R8: parallel join only after both branch requests have been withdrawn
   a_r8_conc_join: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && act_ack) |-> (br_req == '0));

endmodule

bind hsc_ctrl hsc_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_q  (mode_q),
   .act_ack (act_ack),
   .br_req  (br_req),
   .ack_s   (ack_s)
);

// File: tb/hsc_ctrl_tb.sv
`timescale 1ns/1ps
module hsc_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conc_mode = 1'b0;
   logic       act_req = 1'b0;
   logic       act_ack;
   logic [1:0] br_req;
   logic [1:0] br_ack = 2'b00;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   hsc_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .conc_mode (conc_mode),
      .act_req   (act_req),
      .act_ack   (act_ack),
      .br_req    (br_req),
      .br_ack    (br_ack)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // One activation. Called at a falling edge with everything idle.
   // exp_conc: mode the activation must follow; flip: toggle conc_mode mid-way.
   task automatic run_txn(input bit exp_conc, input int d0, input int d1, input bit flip);
      int d[2];
      int cnt[2];
      int r_up[2];
      int r_dn[2];
      int a_up, a_dn, viol, mx;
      logic [1:0] prq;
      logic [1:0] rq;
      logic [1:0] bk;
      logic       aa;
      d[0] = d0; d[1] = d1;
      cnt[0] = 0; cnt[1] = 0;
      r_up[0] = -1; r_up[1] = -1; r_dn[0] = -1; r_dn[1] = -1;
      a_up = -1; a_dn = -1; viol = 0;
      prq = br_req;
      act_req = 1'b1;
      for (int t = 1; t < 100; t++) begin
         @(negedge clk);
         rq = br_req; aa = act_ack; bk = br_ack;
         for (int i = 0; i < 2; i++) begin
            if (rq[i] && !prq[i]) begin
               if (r_up[i] < 0) r_up[i] = t;
               if (bk[i]) viol++;
            end
            if (!rq[i] && prq[i]) begin
               if (r_dn[i] < 0) r_dn[i] = t;
               if (!bk[i]) viol++;
            end
         end
         if (!exp_conc) begin
            if (rq[0] && rq[1]) viol++;
            if (rq[1] && bk[0]) viol++;
            if (aa !== bk[1]) viol++;
         end
         if (aa && a_up < 0) a_up = t;
         if (!aa && a_up >= 0 && a_dn < 0) a_dn = t;
         prq = rq;
         if (a_dn >= 0) break;
         if (flip && t == 2) conc_mode = ~conc_mode;
         for (int i = 0; i < 2; i++) begin
            if (!bk[i] && rq[i]) begin
               cnt[i]++;
               if (cnt[i] == d[i]) begin br_ack[i] = 1'b1; cnt[i] = 0; end
            end else if (bk[i] && !rq[i]) begin
               br_ack[i] = 1'b0;
            end
         end
         if (act_req && aa) act_req = 1'b0;
      end
      chk($sformatf("R11 protocol m=%0d d=%0d/%0d", exp_conc, d0, d1), viol, 0);
      if (!exp_conc) begin
         chk($sformatf("R2 req0 rise d=%0d/%0d", d0, d1), r_up[0], 1);
         chk($sformatf("R3 req0 fall d=%0d/%0d", d0, d1), r_dn[0], d0 + 1);
         chk($sformatf("R3 req1 rise d=%0d/%0d", d0, d1), r_up[1], d0 + 2);
         chk($sformatf("R4 act_ack rise d=%0d/%0d", d0, d1), a_up, d0 + d1 + 2);
         chk($sformatf("R5 req1 fall d=%0d/%0d", d0, d1), r_dn[1], d0 + d1 + 3);
         chk($sformatf("R5 act_ack fall d=%0d/%0d", d0, d1), a_dn, d0 + d1 + 4);
      end else begin
         mx = (d0 > d1) ? d0 : d1;
         chk($sformatf("R6 req0 rise d=%0d/%0d", d0, d1), r_up[0], 1);
         chk($sformatf("R6 req1 rise d=%0d/%0d", d0, d1), r_up[1], 1);
         chk($sformatf("R7 req0 fall d=%0d/%0d", d0, d1), r_dn[0], d0 + 1);
         chk($sformatf("R7 req1 fall d=%0d/%0d", d0, d1), r_dn[1], d1 + 1);
         chk($sformatf("R8 act_ack rise d=%0d/%0d", d0, d1), a_up, mx + 1);
         chk($sformatf("R9 act_ack fall d=%0d/%0d", d0, d1), a_dn, mx + 2);
      end
   endtask

   task automatic set_mode(input bit m);
      conc_mode = m;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset act_ack", int'(act_ack), 0);
      chk("R1 reset br_req", int'(br_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 post-reset act_ack", int'(act_ack), 0);
      chk("R1 post-reset br_req", int'(br_req), 0);

      for (int m = 0; m < 2; m++) begin
         set_mode(m[0]);
         for (int a = 1; a <= 4; a++) begin
            for (int b = 1; b <= 4; b++) begin
               run_txn(m[0], a, b, 1'b0);
               @(negedge clk);
            end
         end
      end

      // R10: a mode change during an activation does not affect it
      set_mode(1'b0);
      run_txn(1'b0, 2, 3, 1'b1);
      repeat (2) @(negedge clk);
      run_txn(1'b1, 3, 1, 1'b0);
      repeat (2) @(negedge clk);
      run_txn(1'b1, 1, 2, 1'b1);
      repeat (2) @(negedge clk);
      run_txn(1'b0, 1, 1, 1'b0);
      chk("R10 idle br_req after mode tests", int'(br_req), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule